// File: doc/BRIEF.md
# Bus Parity Error Reporter

This block sits on the primary side of a bus bridge and watches every address phase and data phase for a parity error. Parity is even and covers the 32 address/data bits together with the 4 command/byte-enable bits. The parity bit for a phase arrives one clock after that phase. The block compares the two and turns any mismatch into the correct response. It can drive the open-drain style system-error strobe, drive the data-parity-error strobe, tell the target decoder not to claim the cycle, or ask the master sequencer to end the transfer with a master abort.

Each strobe is active low and comes with its own output enable. A report pulls the strobe low for one cycle, drives it high for one cycle, and then releases it. Two report slots work independently, one per strobe. Each slot is pipelined, so errors on consecutive phases give consecutive low cycles and no pulse is lost. Reporting is gated by two command-register enables. The bridge's role during the phase (target or master) decides which data errors are reported at all.

Top module: `pbus_parity_reporter`

## Requirements
- R1: A synchronous active-high reset clears all pipeline state. From the first cycle after reset, both output enables are 0, both strobes read 1, and `suppressClaim` and `masterAbortReq` are 0.
- R2: A phase in cycle k has a parity error when the XOR of its 32 `adBus` bits, its 4 `cbeBus` bits and the `parIn` value present in cycle k+1 equals 1 (even parity).
- R3: An address phase in cycle k with a parity error, with both enables high in cycle k+1, gives `serrN`=0 with `serrOe`=1 in cycle k+2. It gives `serrN`=1 with `serrOe`=1 in cycle k+3, and `serrOe`=0 in cycle k+4, unless a later error re-arms the slot.
- R4: If `cmdParityResp` (command bit 6) or `cmdSerrEnable` (command bit 8) is 0 in cycle k+1, an address parity error from cycle k does not move `serrN` or `serrOe`.
- R5: A write data phase with a parity error while `roleMaster`=0 gives `perrN` low for one cycle in cycle k+2, driven high in k+3 and released in k+4. Throughout that report, `perrOe` follows the same pattern as `serrOe` in R3.
- R6: A read data phase with a parity error while `roleMaster`=1 gives the same `perrN` report as R5. A write error while `roleMaster`=1, or a read error while `roleMaster`=0, leaves `perrN` and `perrOe` untouched. `roleMaster` is taken from the phase cycle.
- R7: `perrN` is never asserted for an error whose cycle k+1 has `cmdParityResp`=0.
- R8: Any address parity error from cycle k raises `suppressClaim` for exactly cycle k+2, whatever the enables are.
- R9: A read data parity error from cycle k with `roleMaster`=1 raises `masterAbortReq` for exactly cycle k+2, whatever the enables are.
- R10: Erroneous phases in consecutive cycles each produce their own low cycle on the strobe, in consecutive cycles. The strobe is driven high for one cycle only after the last of them.
- R11: When more than one phase flag is high in one cycle, the address phase takes precedence over the write data phase, and the write data phase takes precedence over the read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addrPhase | input | 1 | Current cycle is an address phase |
| wrDataPhase | input | 1 | Current cycle is a write data phase |
| rdDataPhase | input | 1 | Current cycle is a read data phase |
| adBus | input | 32 | Address/data value of the phase |
| cbeBus | input | 4 | Command/byte-enable value of the phase |
| parIn | input | 1 | Parity bit covering the previous cycle's phase |
| roleMaster | input | 1 | 1 when the bridge is the master of the phase, 0 when target |
| cmdParityResp | input | 1 | Parity response enable (command bit 6) |
| cmdSerrEnable | input | 1 | System-error enable (command bit 8) |
| serrN | output | 1 | System-error strobe, active low |
| serrOe | output | 1 | Output enable for serrN |
| perrN | output | 1 | Data-parity-error strobe, active low |
| perrOe | output | 1 | Output enable for perrN |
| suppressClaim | output | 1 | Tells the target decoder not to claim the cycle |
| masterAbortReq | output | 1 | Asks the master sequencer for a master abort |

## Verification
The main stream is random. It mixes phase kinds, roles, enable settings and parity bits that are correct or flipped. This separates errors gated off by each enable from errors dropped because of the role. Directed runs put errors on back-to-back phases, which shows whether the pipelined slots keep each pulse separate. Other directed runs put an error next to a clean phase, which catches a strobe held too long or released too early. Phases with several flags raised at once expose the precedence order. Single-bit corruptions in the command/byte-enable field show whether those bits are inside the parity coverage.

// File: rtl/pbus_par_pkg.sv
package pbus_par_pkg;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_ADDR  = 2'd1,
    PK_WRITE = 2'd2,
    PK_READ  = 2'd3
  } phase_kind_e;

  typedef struct packed {
    logic addrBad;
    logic wrBad;
    logic rdBad;
    logic asMaster;
  } par_event_t;

  localparam int STROBE_SERR = 0;
  localparam int STROBE_PERR = 1;
  localparam int NUM_STROBES = 2;

endpackage

// File: rtl/pbus_par_datapath.sv
module pbus_par_datapath
  import pbus_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addrPhase,
  input  logic             wrDataPhase,
  input  logic             rdDataPhase,
  input  logic [AD_W-1:0]  adBus,
  input  logic [CBE_W-1:0] cbeBus,
  input  logic             parIn,
  input  logic             roleMaster,
  output par_event_t       evt
);
  localparam int COVER_W = AD_W + CBE_W;

  logic [COVER_W-1:0] coverBits;
  phase_kind_e        kindNow;
  phase_kind_e        kindQ;
  logic               parityQ;
  logic               masterQ;
  logic               mismatch;

  assign coverBits = {adBus, cbeBus};

  // Precedence: address, then write data, then read data (R11)
  always_comb begin
    if (addrPhase)        kindNow = PK_ADDR;
    else if (wrDataPhase) kindNow = PK_WRITE;
    else if (rdDataPhase) kindNow = PK_READ;
    else                  kindNow = PK_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kindQ   <= PK_NONE;
      parityQ <= 1'b0;
      masterQ <= 1'b0;
    end else begin
      kindQ   <= kindNow;
      parityQ <= ^coverBits;
      masterQ <= roleMaster;
    end
  end

  // parIn now covers the phase registered last cycle (R2)
  assign mismatch     = parityQ ^ parIn;
  assign evt.addrBad  = mismatch && (kindQ == PK_ADDR);
  assign evt.wrBad    = mismatch && (kindQ == PK_WRITE);
  assign evt.rdBad    = mismatch && (kindQ == PK_READ);
  assign evt.asMaster = masterQ;

  p_addr_source_r2: assert property (@(posedge clk) disable iff (rst)
    evt.addrBad |-> $past(addrPhase));

  p_write_not_addr_r11: assert property (@(posedge clk) disable iff (rst)
    evt.wrBad |-> ($past(wrDataPhase) && !$past(addrPhase)));

  p_read_lowest_r11: assert property (@(posedge clk) disable iff (rst)
    evt.rdBad |-> ($past(rdDataPhase) && !$past(addrPhase) && !$past(wrDataPhase)));

endmodule

// File: rtl/pbus_par_strobe.sv
module pbus_par_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic strobeN,
  output logic strobeOe
);
  logic assertQ;
  logic highQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      assertQ <= 1'b0;
      highQ   <= 1'b0;
    end else begin
      assertQ <= fire;
      highQ   <= assertQ && !fire;
    end
  end

  assign strobeN  = !assertQ;
  assign strobeOe = assertQ || highQ;

  // R3/R5: strobe is driven high for a cycle before release
  p_high_before_release_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(strobeOe) |-> $past(strobeN));

  p_low_only_driven_r3: assert property (@(posedge clk) disable iff (rst)
    !strobeN |-> strobeOe);

  // R10: every fire gives its own low cycle
  p_fire_to_low_r10: assert property (@(posedge clk) disable iff (rst)
    fire |=> !strobeN);

endmodule

// File: rtl/pbus_par_ctrl.sv
module pbus_par_ctrl
  import pbus_par_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  par_event_t evt,
  input  logic       cmdParityResp,
  input  logic       cmdSerrEnable,
  output logic       serrN,
  output logic       serrOe,
  output logic       perrN,
  output logic       perrOe,
  output logic       suppressClaim,
  output logic       masterAbortReq
);
  logic [NUM_STROBES-1:0] fire;
  logic [NUM_STROBES-1:0] slotN;
  logic [NUM_STROBES-1:0] slotOe;
  logic                   claimQ;
  logic                   abortQ;
  logic                   dataReport;

  // Target reports write errors, master reports read errors (R6)
  assign dataReport = (evt.wrBad && !evt.asMaster) || (evt.rdBad && evt.asMaster);

  assign fire[STROBE_SERR] = evt.addrBad && cmdParityResp && cmdSerrEnable;
  assign fire[STROBE_PERR] = dataReport && cmdParityResp;

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_slot
    pbus_par_strobe u_slot (
      .clk      (clk),
      .rst      (rst),
      .fire     (fire[i]),
      .strobeN  (slotN[i]),
      .strobeOe (slotOe[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      claimQ <= 1'b0;
      abortQ <= 1'b0;
    end else begin
      claimQ <= evt.addrBad;
      abortQ <= evt.rdBad && evt.asMaster;
    end
  end

  assign serrN          = slotN[STROBE_SERR];
  assign serrOe         = slotOe[STROBE_SERR];
  assign perrN          = slotN[STROBE_PERR];
  assign perrOe         = slotOe[STROBE_PERR];
  assign suppressClaim  = claimQ;
  assign masterAbortReq = abortQ;

  p_serr_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !serrN |-> $past(cmdParityResp && cmdSerrEnable));

  p_perr_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !perrN |-> $past(cmdParityResp));

  p_claim_with_serr_r8: assert property (@(posedge clk) disable iff (rst)
    (suppressClaim && $past(cmdParityResp && cmdSerrEnable)) |-> !serrN);

  p_serr_has_claim_r8: assert property (@(posedge clk) disable iff (rst)
    !serrN |-> suppressClaim);

  p_abort_with_perr_r9: assert property (@(posedge clk) disable iff (rst)
    (masterAbortReq && $past(cmdParityResp)) |-> !perrN);

endmodule

// File: rtl/pbus_parity_reporter.sv
module pbus_parity_reporter
  import pbus_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addrPhase,
  input  logic             wrDataPhase,
  input  logic             rdDataPhase,
  input  logic [AD_W-1:0]  adBus,
  input  logic [CBE_W-1:0] cbeBus,
  input  logic             parIn,
  input  logic             roleMaster,
  input  logic             cmdParityResp,
  input  logic             cmdSerrEnable,
  output logic             serrN,
  output logic             serrOe,
  output logic             perrN,
  output logic             perrOe,
  output logic             suppressClaim,
  output logic             masterAbortReq
);
  par_event_t evt;

  pbus_par_datapath #(.AD_W(AD_W), .CBE_W(CBE_W)) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .addrPhase   (addrPhase),
    .wrDataPhase (wrDataPhase),
    .rdDataPhase (rdDataPhase),
    .adBus       (adBus),
    .cbeBus      (cbeBus),
    .parIn       (parIn),
    .roleMaster  (roleMaster),
    .evt         (evt)
  );

  pbus_par_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .evt            (evt),
    .cmdParityResp  (cmdParityResp),
    .cmdSerrEnable  (cmdSerrEnable),
    .serrN          (serrN),
    .serrOe         (serrOe),
    .perrN          (perrN),
    .perrOe         (perrOe),
    .suppressClaim  (suppressClaim),
    .masterAbortReq (masterAbortReq)
  );

  p_perr_enable_r5: assert property (@(posedge clk) disable iff (rst)
    !perrN |-> perrOe);

endmodule

// File: tb/pbus_parity_reporter_bench.sv
module pbus_parity_reporter_bench;
  localparam int HMAX = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addrPhase = 1'b0, wrDataPhase = 1'b0, rdDataPhase = 1'b0;
  logic [31:0] adBus = '0;
  logic [3:0]  cbeBus = '0;
  logic        parIn = 1'b0, roleMaster = 1'b0;
  logic        cmdParityResp = 1'b1, cmdSerrEnable = 1'b1;
  logic        serrN, serrOe, perrN, perrOe, suppressClaim, masterAbortReq;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  bit done   = 0;

  // history of stimuli, by cycle index
  int          hKind [HMAX];  // 0 none, 1 addr, 2 write, 3 read
  logic        hPar  [HMAX];  // even parity of ad+cbe
  logic        hPin  [HMAX];
  logic        hRole [HMAX];
  logic        hEn6  [HMAX];
  logic        hEn8  [HMAX];

  always #5 clk = ~clk;

  pbus_parity_reporter u_pbus_parity_reporter (
    .clk(clk), .rst(rst), .addrPhase(addrPhase), .wrDataPhase(wrDataPhase),
    .rdDataPhase(rdDataPhase), .adBus(adBus), .cbeBus(cbeBus), .parIn(parIn),
    .roleMaster(roleMaster), .cmdParityResp(cmdParityResp),
    .cmdSerrEnable(cmdSerrEnable), .serrN(serrN), .serrOe(serrOe),
    .perrN(perrN), .perrOe(perrOe), .suppressClaim(suppressClaim),
    .masterAbortReq(masterAbortReq)
  );

  // R2: error when parity of phase j disagrees with parIn of j+1
  function automatic bit errAt(int j);
    if (j < 0) return 0;
    if (hKind[j] == 0) return 0;
    return (hPar[j] ^ hPin[j+1]) == 1'b1;
  endfunction
  function automatic bit addrEv(int j);
    return (j >= 0) && hKind[j] == 1 && errAt(j);
  endfunction
  function automatic bit dataEv(int j);  // R6 role filter
    if (j < 0) return 0;
    return errAt(j) && ((hKind[j] == 2 && !hRole[j]) || (hKind[j] == 3 && hRole[j]));
  endfunction
  function automatic bit rdMasterEv(int j);
    return (j >= 0) && hKind[j] == 3 && hRole[j] && errAt(j);
  endfunction
  function automatic bit serrLow(int c);  // R3, R4
    if (c < 2) return 0;
    return addrEv(c-2) && hEn6[c-1] && hEn8[c-1];
  endfunction
  function automatic bit perrLow(int c);  // R5, R7
    if (c < 2) return 0;
    return dataEv(c-2) && hEn6[c-1];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, t, act, exp);
    end
  endtask

  // drive one cycle: check outputs of cycle t, then apply inputs of cycle t
  task automatic step(int kind, bit multi, logic [31:0] ad, logic [3:0] cbe,
                      bit role, bit en6, bit en8, bit corruptPrev);
    @(negedge clk);
    check("R3 serrN",          serrN,          !serrLow(t));
    check("R3 serrOe",         serrOe,         serrLow(t) || (t >= 1 && serrLow(t-1)));
    check("R5 perrN",          perrN,          !perrLow(t));
    check("R5 perrOe",         perrOe,         perrLow(t) || (t >= 1 && perrLow(t-1)));
    check("R8 suppressClaim",  suppressClaim,  (t >= 2) && addrEv(t-2));
    check("R9 masterAbortReq", masterAbortReq, (t >= 2) && rdMasterEv(t-2));
    // R11: multi raises lower-priority flags as well
    addrPhase   = (kind == 1);
    wrDataPhase = (kind == 2) || (multi && kind == 1);
    rdDataPhase = (kind == 3) || (multi && kind != 0);
    adBus = ad; cbeBus = cbe; roleMaster = role;
    cmdParityResp = en6; cmdSerrEnable = en8;
    parIn = ((t >= 1) ? hPar[t-1] : 1'b0) ^ corruptPrev;
    hKind[t] = kind; hPar[t] = ^{ad, cbe}; hPin[t] = parIn;
    hRole[t] = role; hEn6[t] = en6; hEn8[t] = en8;
    t++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 32'h0, 4'h0, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // phases with bad parity during reset must leave no trace (R1)
    rst = 1'b1;
    addrPhase = 1'b1; wrDataPhase = 1'b0; rdDataPhase = 1'b0;
    adBus = 32'h1; parIn = 1'b0;
    repeat (4) @(negedge clk);
    parIn = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    addrPhase = 1'b0;
    parIn = 1'b0;
    @(posedge clk);
    #1;
    check("R1 serrOe",  serrOe, 1'b0);
    check("R1 perrOe",  perrOe, 1'b0);
    check("R1 serrN",   serrN,  1'b1);
    check("R1 perrN",   perrN,  1'b1);
    check("R1 claim",   suppressClaim, 1'b0);
    check("R1 abort",   masterAbortReq, 1'b0);
    t = 1;  // cycle 0 already run with no phase
    hKind[0] = 0; hPar[0] = 0; hPin[0] = 0; hRole[0] = 0; hEn6[0] = 1; hEn8[0] = 1;

    // R3: single address error, enables on
    step(1, 0, 32'hDEAD_BEEF, 4'h6, 0, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(4);
    // R4: each enable off in the parity cycle
    step(1, 0, 32'h1234_5678, 4'h7, 0, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 0, 1);
    idle(3);
    step(1, 0, 32'h1234_5678, 4'h7, 0, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, 1);
    idle(3);
    // R5: write error as target; R6 write error as master ignored
    step(2, 0, 32'h0F0F_0F0F, 4'h0, 0, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(3);
    step(2, 0, 32'h0F0F_0F0F, 4'h0, 1, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(3);
    // R6 and R9: read as master reported, read as target not
    step(3, 0, 32'hAAAA_5555, 4'hC, 1, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(3);
    step(3, 0, 32'hAAAA_5555, 4'hC, 0, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(3);
    // R7: parity response off, R9 abort still raised
    step(3, 0, 32'h8000_0001, 4'h1, 1, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 0, 0, 1);
    idle(3);
    // R10: back-to-back address errors, then back-to-back writes
    step(1, 0, 32'h1, 4'h1, 0, 1, 1, 0);
    step(1, 0, 32'h2, 4'h2, 0, 1, 1, 1);
    step(1, 0, 32'h3, 4'h3, 0, 1, 1, 1);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(4);
    step(2, 0, 32'h5, 4'h0, 0, 1, 1, 0);
    step(2, 0, 32'h6, 4'h0, 0, 1, 1, 1);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(4);
    // R11: address plus data flags together act as address
    step(1, 1, 32'h7, 4'h9, 1, 1, 1, 0);
    step(2, 1, 32'h8, 4'h9, 0, 1, 1, 1);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 1);
    idle(4);
    // R2: clean parity gives nothing; cbe bit covered
    step(1, 0, 32'hFFFF_0000, 4'h8, 0, 1, 1, 0);
    step(0, 0, 32'h0, 4'h0, 0, 1, 1, 0);
    idle(3);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 3);
      step(k, ($urandom_range(0, 7) == 0), $urandom, 4'($urandom),
           $urandom_range(0, 1), ($urandom_range(0, 4) != 0),
           ($urandom_range(0, 4) != 0), ($urandom_range(0, 2) == 0));
    end
    idle(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule